// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by reading descriptors from a two-level translation table held in physical memory. A client pulses a start strobe with the missing virtual address and the current translation table base. The walker issues one word read for the first-level descriptor. Depending on that descriptor, it either finishes (section mapping or fault) or issues a second word read for a page-table entry. It then reports a single result: the translated physical address, the mapping size, the cacheable/bufferable bits, the domain number, the access-permission fields, or a fault code.

Descriptor reads go through a request channel with valid/ready handshaking and a separate response channel. The response carries the data word and an error flag. Either channel may stall for any number of cycles. The result registers hold their values after the one-cycle completion pulse, so a lookaside buffer can capture them at leisure. Permission evaluation and entry storage belong to the client.

Top module: `xlat_walker`

## Requirements
- R1: The first descriptor read goes to address {base[31:14], va[31:20], 2'b00}. Bits [13:0] of the supplied base are ignored.
- R2: A first-level word whose bits [1:0] are 2'b10 ends the walk after exactly one read. The result then has size code 2'b10, physical address {d[31:20], va[19:0]}, C/B from d[3:2], domain from d[8:5] and status 4'b0000. The permission field is d[11:10] copied into all four 2-bit slots.
- R3: A first-level word whose bits [1:0] are 2'b00 or 2'b11 ends the walk after one read, with the fault flag set, status 4'b0101 and domain 0.
- R4: A first-level word with bits [1:0] = 2'b01 causes a second read at {d1[31:10], va[19:12], 2'b00}. The reported domain is d1[8:5].
- R5: A second-level word with bits [1:0] = 2'b10 gives size code 2'b00, physical address {d2[31:12], va[11:0]}, C/B from d2[3:2], permissions d2[11:4] and status 4'b0000.
- R6: A second-level word with bits [1:0] = 2'b01 gives size code 2'b01 and physical address {d2[31:16], va[15:0]}. Its C/B and permissions come from the same fields as in R5.
- R7: A second-level word with bits [1:0] = 2'b00 or 2'b11 sets the fault flag with status 4'b0111 and the first-level domain.
- R8: A response carrying the error flag ends the walk with the fault flag set. The status is 4'b1100 on the first read and 4'b1110 on the second.
- R9: A read request keeps valid high and its address unchanged until ready is seen. Any number of stall cycles on ready or on the response is tolerated.
- R10: busy is high from the cycle after an accepted start until the completion pulse, which lasts exactly one cycle. A start strobe seen while busy is ignored.
- R11: All result outputs stay unchanged from the completion pulse until the next accepted walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Begin a walk (accepted only when idle) |
| start_va | input | 32 | Virtual address that missed |
| ttb | input | 32 | Translation table base; bits [31:14] used |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| mem_rsp_err | input | 1 | Read terminated with an external error |
| res_pa | output | 32 | Translated physical address |
| res_size | output | 2 | 2'b10 section, 2'b01 large page, 2'b00 small page |
| res_cb | output | 2 | Cacheable / bufferable bits |
| res_domain | output | 4 | Domain number |
| res_ap | output | 8 | Four 2-bit permission fields |
| res_fault | output | 1 | Walk ended in a fault |
| res_status | output | 4 | Fault status code, 0 when no fault |

## Verification
On every cycle, the embedded properties check that a stalled request holds its address and that the completion pulse is one cycle wide. They also check that busy only drops after that pulse, that results do not move while the walker is idle, and that any reported status is one of the four fault codes. Whether the descriptor addresses are concatenated correctly, and whether each descriptor type decodes to the right address, size, attributes and code, can only be shown by the bench's directed walks. Each of those walks runs against a memory model with chosen contents, stall lengths and injected errors. The same holds for the rule that a start arriving mid-walk leaves the walk untouched.

// File: rtl/xlat_walker.sv
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  input  logic [31:0] start_va,
  input  logic [31:0] ttb,
  output logic        busy,
  output logic        done,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic [31:0] res_pa,
  output logic [1:0]  res_size,
  output logic [1:0]  res_cb,
  output logic [3:0]  res_domain,
  output logic [7:0]  res_ap,
  output logic        res_fault,
  output logic [3:0]  res_status
);

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE} st_t;

  localparam logic [1:0] SZ_SMALL   = 2'b00;
  localparam logic [1:0] SZ_LARGE   = 2'b01;
  localparam logic [1:0] SZ_SECTION = 2'b10;

  localparam logic [3:0] FS_L1_XLAT  = 4'b0101;
  localparam logic [3:0] FS_L2_XLAT  = 4'b0111;
  localparam logic [3:0] FS_L1_ABORT = 4'b1100;
  localparam logic [3:0] FS_L2_ABORT = 4'b1110;

  st_t         st;
  logic [31:0] va_q;
  logic [17:0] base_q;
  logic [31:0] l1_q;
  logic [31:0] d;

  assign d             = mem_rsp_data;
  assign busy          = (st != S_IDLE);
  assign done          = (st == S_DONE);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_req_addr  = (st == S_L2_REQ) ? {l1_q[31:10], va_q[19:12], 2'b00}
                                          : {base_q, va_q[31:20], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      base_q     <= '0;
      l1_q       <= '0;
      res_pa     <= '0;
      res_size   <= '0;
      res_cb     <= '0;
      res_domain <= '0;
      res_ap     <= '0;
      res_fault  <= 1'b0;
      res_status <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_valid) begin
          va_q   <= start_va;
          base_q <= ttb[31:14];
          st     <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            res_pa     <= '0;
            res_size   <= '0;
            res_cb     <= '0;
            res_domain <= '0;
            res_ap     <= '0;
            res_fault  <= 1'b1;
            res_status <= FS_L1_ABORT;
            st         <= S_DONE;
          end else if (d[1:0] == 2'b10) begin
            res_pa     <= {d[31:20], va_q[19:0]};
            res_size   <= SZ_SECTION;
            res_cb     <= d[3:2];
            res_domain <= d[8:5];
            res_ap     <= {4{d[11:10]}};
            res_fault  <= 1'b0;
            res_status <= '0;
            st         <= S_DONE;
          end else if (d[1:0] == 2'b01) begin
            l1_q <= d;
            st   <= S_L2_REQ;
          end else begin
            res_pa     <= '0;
            res_size   <= '0;
            res_cb     <= '0;
            res_domain <= '0;
            res_ap     <= '0;
            res_fault  <= 1'b1;
            res_status <= FS_L1_XLAT;
            st         <= S_DONE;
          end
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          res_domain <= l1_q[8:5];
          st         <= S_DONE;
          if (mem_rsp_err) begin
            res_pa     <= '0;
            res_size   <= '0;
            res_cb     <= '0;
            res_ap     <= '0;
            res_fault  <= 1'b1;
            res_status <= FS_L2_ABORT;
          end else if (d[1:0] == 2'b10) begin
            res_pa     <= {d[31:12], va_q[11:0]};
            res_size   <= SZ_SMALL;
            res_cb     <= d[3:2];
            res_ap     <= d[11:4];
            res_fault  <= 1'b0;
            res_status <= '0;
          end else if (d[1:0] == 2'b01) begin
            res_pa     <= {d[31:16], va_q[15:0]};
            res_size   <= SZ_LARGE;
            res_cb     <= d[3:2];
            res_ap     <= d[11:4];
            res_fault  <= 1'b0;
            res_status <= '0;
          end else begin
            res_pa     <= '0;
            res_size   <= '0;
            res_cb     <= '0;
            res_ap     <= '0;
            res_fault  <= 1'b1;
            res_status <= FS_L2_XLAT;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable({res_pa, res_size, res_cb, res_domain, res_ap, res_fault, res_status}));

  p_status_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault |-> (res_status == FS_L1_XLAT) || (res_status == FS_L2_XLAT) ||
                          (res_status == FS_L1_ABORT) || (res_status == FS_L2_ABORT));

  p_ok_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_fault |-> res_status == 4'b0000 && res_size != 2'b11);

endmodule

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_valid = 0;
  logic [31:0] start_va = '0;
  logic [31:0] ttb = '0;
  logic        busy, done, mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 0;
  logic [31:0] res_pa;
  logic [1:0]  res_size, res_cb;
  logic [3:0]  res_domain, res_status;
  logic [7:0]  res_ap;
  logic        res_fault;

  always #2.5 clk = ~clk;

  xlat_walker u_xlat_walker (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] mem_a [8];
  logic [31:0] mem_d [8];
  int          mem_n = 0;
  logic [31:0] err_addr = '0;
  logic        err_en = 0;
  int          rdy_wait = 0;
  int          rsp_wait = 0;
  int          nfetch = 0;
  logic [31:0] fa [4];
  int          stall_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] r = '0;
    for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) r = mem_d[i];
    return r;
  endfunction

  task automatic mem_reset();
    mem_n = 0; err_en = 0; nfetch = 0;
  endtask

  task automatic mem_put(input logic [31:0] a, input logic [31:0] v);
    mem_a[mem_n] = a; mem_d[mem_n] = v; mem_n++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 0;
      mem_rsp_valid = 0;
      mem_rsp_err = 0;
      if (mem_req_valid) begin
        logic [31:0] a0;
        a0 = mem_req_addr;
        for (int i = 0; i < rdy_wait; i++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr !== a0) stall_bad++;
        end
        mem_req_ready = 1;
        if (nfetch < 4) fa[nfetch] = mem_req_addr;
        nfetch++;
        @(negedge clk);
        mem_req_ready = 0;
        for (int i = 0; i < rsp_wait; i++) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data  = lookup(a0);
        mem_rsp_err   = err_en && (a0 == err_addr);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] tb);
    nfetch = 0;
    @(negedge clk);
    start_valid = 1; start_va = va; ttb = tb;
    @(negedge clk);
    start_valid = 0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] l1a(input logic [31:0] tb, input logic [31:0] va);
    return {tb[31:14], va[31:20], 2'b00};
  endfunction

  task automatic t_reset();
    chk("R10 busy after reset", busy, 0);
    chk("R10 done after reset", done, 0);
    chk("R9 no request after reset", mem_req_valid, 0);
  endtask

  task automatic t_section();
    logic [31:0] tb = 32'h1234_C123, va = 32'hABC1_2345, d;
    d = {12'h567, 8'h00, 2'b10, 1'b0, 4'd9, 1'b1, 2'b11, 2'b10};
    mem_reset(); rdy_wait = 2; rsp_wait = 3;
    mem_put(l1a(tb, va), d);
    walk(va, tb);
    chk("R1 first read address", fa[0], l1a(tb, va));
    chk("R2 one read", nfetch, 1);
    chk("R2 section pa", res_pa, {d[31:20], va[19:0]});
    chk("R2 size", res_size, 2'b10);
    chk("R2 cb", res_cb, 2'b11);
    chk("R2 domain", res_domain, 9);
    chk("R2 ap", res_ap, 8'hAA);
    chk("R2 no fault", {res_fault, res_status}, 0);
    chk("R9 stall hold", stall_bad, 0);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 idle after done", busy, 0);
    repeat (5) @(negedge clk);
    chk("R11 pa held", res_pa, {d[31:20], va[19:0]});
  endtask

  task automatic t_l1_bad(input logic [1:0] ty);
    logic [31:0] tb = 32'h0004_0000, va = 32'h0030_0000;
    mem_reset(); rdy_wait = 0; rsp_wait = 0;
    mem_put(l1a(tb, va), {30'h3FFF_FFFF, ty});
    walk(va, tb);
    chk("R3 one read", nfetch, 1);
    chk("R3 fault", res_fault, 1);
    chk("R3 status", res_status, 4'b0101);
    chk("R3 domain", res_domain, 0);
  endtask

  task automatic t_page(input logic [1:0] ty, input int rw, input int sw);
    logic [31:0] tb = 32'h8000_4000, va = 32'h2A5B_CDEF, d1, d2, l2;
    d1 = {22'h2_AAAA, 1'b0, 4'd5, 1'b1, 2'b00, 2'b01};
    d2 = {20'hF00D5, 8'b11_10_01_00, 2'b01, ty};
    l2 = {d1[31:10], va[19:12], 2'b00};
    mem_reset(); rdy_wait = rw; rsp_wait = sw; stall_bad = 0;
    mem_put(l1a(tb, va), d1);
    mem_put(l2, d2);
    walk(va, tb);
    chk("R4 two reads", nfetch, 2);
    chk("R4 second read address", fa[1], l2);
    chk("R4 domain", res_domain, 5);
    chk("R9 stall hold", stall_bad, 0);
    if (ty == 2'b10) begin
      chk("R5 small pa", res_pa, {d2[31:12], va[11:0]});
      chk("R5 size", res_size, 2'b00);
      chk("R5 ap", res_ap, 8'hE4);
      chk("R5 cb", res_cb, 2'b01);
      chk("R5 no fault", {res_fault, res_status}, 0);
    end else if (ty == 2'b01) begin
      chk("R6 large pa", res_pa, {d2[31:16], va[15:0]});
      chk("R6 size", res_size, 2'b01);
      chk("R6 ap", res_ap, 8'hE4);
      chk("R6 cb", res_cb, 2'b01);
    end else begin
      chk("R7 fault", res_fault, 1);
      chk("R7 status", res_status, 4'b0111);
    end
  endtask

  task automatic t_abort(input bit second);
    logic [31:0] tb = 32'h0010_0000, va = 32'h7770_1000, d1, l2;
    d1 = {22'h00_1234, 1'b0, 4'd12, 1'b1, 2'b00, 2'b01};
    l2 = {d1[31:10], va[19:12], 2'b00};
    mem_reset(); rdy_wait = 1; rsp_wait = 2;
    mem_put(l1a(tb, va), d1);
    mem_put(l2, 32'h1234_5FF2);
    err_en = 1; err_addr = second ? l2 : l1a(tb, va);
    walk(va, tb);
    chk("R8 fault", res_fault, 1);
    chk("R8 status", res_status, second ? 4'b1110 : 4'b1100);
    chk("R8 reads", nfetch, second ? 2 : 1);
  endtask

  task automatic t_start_ignored();
    logic [31:0] tb = 32'h0000_8000, va = 32'h0120_0ABC, d;
    d = {12'hFED, 8'h00, 2'b01, 1'b0, 4'd3, 1'b1, 2'b00, 2'b10};
    mem_reset(); rdy_wait = 3; rsp_wait = 4;
    mem_put(l1a(tb, va), d);
    nfetch = 0;
    @(negedge clk);
    start_valid = 1; start_va = va; ttb = tb;
    @(negedge clk);
    start_valid = 0;
    chk("R10 busy after start", busy, 1);
    @(negedge clk);
    start_valid = 1; start_va = 32'hFFFF_FFFF; ttb = 32'hFFFF_C000;
    @(negedge clk);
    start_valid = 0;
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    chk("R10 ignored start pa", res_pa, {d[31:20], va[19:0]});
    chk("R10 ignored start reads", nfetch, 1);
    chk("R10 ignored start address", fa[0], l1a(tb, va));
    repeat (4) @(negedge clk);
    chk("R10 no second walk", busy, 0);
    chk("R11 domain held", res_domain, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_section();
    t_l1_bad(2'b00);
    t_l1_bad(2'b11);
    t_page(2'b10, 0, 0);
    t_page(2'b10, 4, 1);
    t_page(2'b01, 1, 5);
    t_page(2'b00, 0, 2);
    t_page(2'b11, 2, 0);
    t_abort(0);
    t_abort(1);
    t_start_ignored();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule